// File: doc/BRIEF.md
# Register-Driven Packet Transmit Endpoint

This block is the transmit half of a small packet endpoint, driven by a processor through a bank of seven 16-bit registers. Software writes payload words one at a time into a data register, and the block collects them in an internal buffer. Software then sets the flush bit in the control register. The block first emits a four-word header that it builds itself, then the buffered payload, on a 16-bit stream with valid, ready and last. The header carries the remote and local addresses, a packet type, a block counter that the hardware maintains, and the payload length in bytes.

Sequencing is held in a three-state machine. `SEQ_IDLE` accepts payload words. A flush moves it to `SEQ_HEAD`. `SEQ_HEAD` sends header words 0 to 3 and, after word 3 is accepted, moves to `SEQ_BODY`, or back to `SEQ_IDLE` when the buffer is empty. `SEQ_BODY` sends one buffered word per handshake and returns to `SEQ_IDLE` when the final word is accepted. On that return the buffer is emptied, the block counter advances and the done event is raised. Status bits and a maskable interrupt report the state to software.

Top module: `pkt_tx_endpoint`

## Requirements
- R1: Register word addresses are: 0 payload data (write), 1 control, 2 receive data (always reads 0), 3 status, 4 local address, 5 remote address, 6 interrupt. Addresses 4 and 5 read back what was written.
- R2: The header is four words in this order: the remote address, the local address, then {packet type in bits 15:8, block counter in bits 7:0}, then the payload length in bytes, which is twice the number of buffered words.
- R3: The payload words follow the header in the order they were written. `tx_last` is high only on the final word: header word 3 when the buffer is empty, otherwise the last payload word.
- R4: A control write with bit 15 set, made while idle, starts a packet. Control bits 7:0 set the packet type and read back at address 1.
- R5: The block counter is 0 after reset, rises by one for each completed packet, and wraps from 255 to 0.
- R6: Status bit 0 is high while idle with at least one word buffered. Bit 1 is high while a packet is being sent. Bit 2 is high when the buffer holds DEPTH words.
- R7: A payload write while the buffer is full is dropped and sets status bit 3. A status read returns that bit and then clears it.
- R8: While a packet is being sent, payload writes and flush requests have no effect.
- R9: At address 6, bit 5 shows the buffer is free (not sending and not full). Bit 6 is the done event, cleared by writing 1 to it. Bits 13 and 14 enable bits 5 and 6. `irq` equals (bit5 AND bit13) OR (bit6 AND bit14).
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` stay unchanged.
- R11: After reset the status reads 0, the interrupt register reads 0x0020, `tx_valid` is low and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register word address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from reg_addr |
| tx_data | output | 16 | Stream word |
| tx_valid | output | 1 | Stream word valid |
| tx_ready | input | 1 | Stream sink ready |
| tx_last | output | 1 | Final word of the packet |
| irq | output | 1 | Interrupt request |

## Verification
A register write takes effect at the clock edge that samples it, so status, read-back and buffered count are visible one cycle later. The bench drives each access on a falling edge and reads on the next falling edge. The first header word appears on the stream in the cycle after the flush edge. Each word changes in the cycle after the edge that accepts it, so the bench compares the word at the falling edge before the accepting rising edge. The done event, the counter increment and the emptied buffer all appear after the edge that accepts the last word, and the bench reads them one falling edge later.

// File: rtl/txe_pkg.sv
package txe_pkg;
    localparam int REG_AW = 3;
    localparam logic [REG_AW-1:0] A_DATA  = 3'd0;
    localparam logic [REG_AW-1:0] A_CTRL  = 3'd1;
    localparam logic [REG_AW-1:0] A_RXD   = 3'd2;
    localparam logic [REG_AW-1:0] A_STAT  = 3'd3;
    localparam logic [REG_AW-1:0] A_LOCAL = 3'd4;
    localparam logic [REG_AW-1:0] A_REMOT = 3'd5;
    localparam logic [REG_AW-1:0] A_IRQ   = 3'd6;

    localparam int HDR_WORDS = 4;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_HEAD = 2'd1,
        SEQ_BODY = 2'd2
    } seq_state_t;
endpackage

// File: rtl/txe_buffer.sv
module txe_buffer #(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int PW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [15:0]   push_word,
    input  logic          pop,
    input  logic          clear,
    output logic [CW-1:0] count,
    output logic [PW-1:0] rd_ptr,
    output logic [15:0]   head_word,
    output logic          full
);
    logic [15:0] mem [DEPTH];

    assign full      = (count == CW'(DEPTH));
    assign head_word = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push && !full) mem[count[PW-1:0]] <= push_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count  <= '0;
            rd_ptr <= '0;
        end else begin
            if (push && !full) count <= count + 1'b1;
            if (pop) rd_ptr <= rd_ptr + 1'b1;
        end
    end
endmodule

// File: rtl/txe_seq.sv
module txe_seq
    import txe_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int PW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] count,
    input  logic [PW-1:0] rd_ptr,
    input  logic [15:0]   body_word,
    input  logic [15:0]   hdr_remote,
    input  logic [15:0]   hdr_local,
    input  logic [7:0]    hdr_type,
    input  logic [7:0]    hdr_blk,
    input  logic          tx_ready,
    output logic [15:0]   tx_data,
    output logic          tx_valid,
    output logic          tx_last,
    output logic          busy,
    output logic          pop,
    output logic          done
);
    seq_state_t state, nstate;
    logic [1:0] hidx;
    logic       hdr_end, body_end;

    assign hdr_end  = (hidx == 2'(HDR_WORDS - 1));
    assign body_end = ({1'b0, rd_ptr} == CW'(count - 1'b1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
            hidx  <= '0;
        end else begin
            state <= nstate;
            if (state == SEQ_HEAD && tx_ready) hidx <= hidx + 1'b1;
            else if (state == SEQ_IDLE) hidx <= '0;
        end
    end

    always_comb begin
        nstate = state;
        unique case (state)
            SEQ_IDLE: if (start) nstate = SEQ_HEAD;
            SEQ_HEAD: if (tx_ready && hdr_end)
                          nstate = (count == '0) ? SEQ_IDLE : SEQ_BODY;
            SEQ_BODY: if (tx_ready && body_end) nstate = SEQ_IDLE;
            default:  nstate = SEQ_IDLE;
        endcase
    end

    always_comb begin
        tx_valid = 1'b0;
        tx_last  = 1'b0;
        tx_data  = '0;
        pop      = 1'b0;
        done     = 1'b0;
        busy     = (state != SEQ_IDLE);
        unique case (state)
            SEQ_IDLE: ;
            SEQ_HEAD: begin
                tx_valid = 1'b1;
                unique case (hidx)
                    2'd0: tx_data = hdr_remote;
                    2'd1: tx_data = hdr_local;
                    2'd2: tx_data = {hdr_type, hdr_blk};
                    default: tx_data = {count, 1'b0};
                endcase
                tx_last = hdr_end && (count == '0);
                done    = tx_ready && tx_last;
            end
            SEQ_BODY: begin
                tx_valid = 1'b1;
                tx_data  = body_word;
                tx_last  = body_end;
                pop      = tx_ready;
                done     = tx_ready && body_end;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/txe_irq.sv
module txe_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic done,
    input  logic free,
    input  logic wr,
    input  logic [15:0] wdata,
    output logic ev_done,
    output logic en_free,
    output logic en_done,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_done <= 1'b0;
            en_free <= 1'b0;
            en_done <= 1'b0;
        end else begin
            if (done) ev_done <= 1'b1;
            else if (wr && wdata[6]) ev_done <= 1'b0;
            if (wr) begin
                en_free <= wdata[13];
                en_done <= wdata[14];
            end
        end
    end

    assign irq = (free && en_free) || (ev_done && en_done);
endmodule

// File: rtl/pkt_tx_endpoint.sv
module pkt_tx_endpoint
    import txe_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int PW = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  reg_addr,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic [15:0] tx_data,
    output logic        tx_valid,
    input  logic        tx_ready,
    output logic        tx_last,
    output logic        irq
);
    logic [15:0]   local_addr, remote_addr;
    logic [7:0]    pkt_type, blk_ctr;
    logic          err, busy, full, pop, done, push, start;
    logic          ev_done, en_free, en_done, free;
    logic [CW-1:0] count;
    logic [PW-1:0] rd_ptr;
    logic [15:0]   head_word;

    assign push  = reg_wr && (reg_addr == A_DATA) && !busy;
    assign start = reg_wr && (reg_addr == A_CTRL) && reg_wdata[15] && !busy;
    assign free  = !busy && !full;

    txe_buffer #(.DEPTH(DEPTH)) u_buf (
        .clk(clk), .rst_n(rst_n), .push(push), .push_word(reg_wdata),
        .pop(pop), .clear(done), .count(count), .rd_ptr(rd_ptr),
        .head_word(head_word), .full(full)
    );

    txe_seq #(.DEPTH(DEPTH)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .count(count),
        .rd_ptr(rd_ptr), .body_word(head_word), .hdr_remote(remote_addr),
        .hdr_local(local_addr), .hdr_type(pkt_type), .hdr_blk(blk_ctr),
        .tx_ready(tx_ready), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_last(tx_last), .busy(busy), .pop(pop), .done(done)
    );

    txe_irq u_irq (
        .clk(clk), .rst_n(rst_n), .done(done), .free(free),
        .wr(reg_wr && reg_addr == A_IRQ), .wdata(reg_wdata),
        .ev_done(ev_done), .en_free(en_free), .en_done(en_done), .irq(irq)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            local_addr  <= '0;
            remote_addr <= '0;
            pkt_type    <= '0;
            blk_ctr     <= '0;
            err         <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == A_LOCAL) local_addr  <= reg_wdata;
            if (reg_wr && reg_addr == A_REMOT) remote_addr <= reg_wdata;
            if (reg_wr && reg_addr == A_CTRL && !busy) pkt_type <= reg_wdata[7:0];
            if (done) blk_ctr <= blk_ctr + 1'b1;
            if (push && full) err <= 1'b1;
            else if (reg_rd && reg_addr == A_STAT) err <= 1'b0;
        end
    end

    always_comb begin
        unique case (reg_addr)
            A_CTRL:  reg_rdata = {8'h00, pkt_type};
            A_STAT:  reg_rdata = {12'h000, err, full, busy, (!busy && count != '0)};
            A_LOCAL: reg_rdata = local_addr;
            A_REMOT: reg_rdata = remote_addr;
            A_IRQ:   reg_rdata = {1'b0, en_done, en_free, 6'd0, ev_done, free, 5'd0};
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/txe_checker.sv
module txe_checker #(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    reg_addr,
    input logic          reg_wr,
    input logic          reg_rd,
    input logic          tx_valid,
    input logic          tx_ready,
    input logic          tx_last,
    input logic [15:0]   tx_data,
    input logic          busy,
    input logic [CW-1:0] count,
    input logic          err,
    input logic          ev_done
);
    assert_hold_stream_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    assert_last_needs_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);

    assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    assert_frozen_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(count)));

    assert_err_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_wr && reg_addr == 3'd3) |=> !err);

    assert_done_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ev_done);
endmodule

bind pkt_tx_endpoint txe_checker #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_last(tx_last), .tx_data(tx_data), .busy(busy), .count(count),
    .err(err), .ev_done(ev_done)
);

// File: tb/tb_pkt_tx_endpoint.sv
module tb_pkt_tx_endpoint;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata, tx_data;
    logic tx_valid, tx_ready = 1'b0, tx_last, irq;

    int checks = 0;
    int errors = 0;
    int pkts = 0;
    logic [15:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_tx_endpoint #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_last(tx_last), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    function automatic logic [15:0] pw(input int n, input int i);
        return 16'((n * 37 + i * 5) ^ 16'h5A3C);
    endfunction

    // Receive one packet of n payload words and compare every word (R2, R3, R5).
    task automatic recv(input int n, input logic [15:0] rem, input logic [15:0] loc,
                        input logic [7:0] typ, input int stall_seed);
        int j = 0;
        int cyc = 0;
        logic [15:0] exp;
        while (j <= 3 + n && cyc < 1000) begin
            @(negedge clk);
            tx_ready = ((cyc + stall_seed) % 3) != 0;
            #1;
            if (tx_valid && tx_ready) begin
                if (j == 0) exp = rem;
                else if (j == 1) exp = loc;
                else if (j == 2) exp = {typ, 8'(pkts)};
                else if (j == 3) exp = 16'(2 * n);
                else exp = pw(n, j - 4);
                if (j < 4) check("R2 header word", tx_data, exp);
                else check("R3 payload word", tx_data, exp);
                check("R3 last flag", tx_last, (j == 3 + n));
                j++;
            end
            cyc++;
        end
        @(negedge clk);
        tx_ready = 1'b0;
        pkts++;
        check("R3 packet complete", j, 4 + n);
    endtask

    task automatic send(input int n, input int seed);
        logic [15:0] rem = 16'hB000 ^ 16'(n);
        logic [15:0] loc = 16'h1000 + 16'(n);
        logic [7:0]  typ = 8'(n) + 8'h40;
        wr(3'd5, rem);
        wr(3'd4, loc);
        for (int i = 0; i < n; i++) wr(3'd0, pw(n, i));
        wr(3'd1, {8'h80, typ});
        recv(n, rem, loc, typ, seed);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11 tx_valid", tx_valid, 0);
        check("R11 irq", irq, 0);
        rd(3'd3, rv); check("R11 status", rv, 16'h0000);
        rd(3'd6, rv); check("R11 irq reg", rv, 16'h0020);
        // R1 register map
        wr(3'd4, 16'h1234); rd(3'd4, rv); check("R1 local readback", rv, 16'h1234);
        wr(3'd5, 16'hABCD); rd(3'd5, rv); check("R1 remote readback", rv, 16'hABCD);
        rd(3'd2, rv); check("R1 rx data zero", rv, 16'h0000);
        // R9 free interrupt
        wr(3'd6, 16'h2000); @(negedge clk); check("R9 irq free enabled", irq, 1);
        // R6 building
        wr(3'd0, 16'h0101); rd(3'd3, rv); check("R6 building bit", rv, 16'h0001);
        // R4 type readback and R8 writes ignored while sending
        wr(3'd1, 16'h0077); rd(3'd1, rv); check("R4 type readback", rv, 16'h0077);
        wr(3'd1, 16'h8077);
        rd(3'd3, rv); check("R6 transmitting bit", rv, 16'h0002);
        wr(3'd0, 16'hDEAD);
        wr(3'd1, 16'h8011);
        rd(3'd1, rv); check("R8 type unchanged while sending", rv, 16'h0077);
        begin
            int j = 0;
            int guard = 0;
            logic [15:0] exp;
            while (j < 5 && guard < 100) begin
                @(negedge clk); tx_ready = 1'b1; #1;
                if (tx_valid) begin
                    exp = (j == 0) ? 16'hABCD : (j == 1) ? 16'h1234 :
                          (j == 2) ? 16'h7700 : (j == 3) ? 16'h0002 : 16'h0101;
                    check("R8 packet unaffected", tx_data, exp);
                    check("R3 last", tx_last, j == 4);
                    j++;
                end
                guard++;
            end
            @(negedge clk); tx_ready = 1'b0;
            pkts++;
        end
        rd(3'd3, rv); check("R8 buffer empty after send", rv, 16'h0000);
        @(negedge clk); check("R8 no second packet", tx_valid, 0);
        // R9 done event and W1C
        rd(3'd6, rv); check("R9 done event set", rv, 16'h2060);
        wr(3'd6, 16'h4000); @(negedge clk); check("R9 irq done", irq, 1);
        wr(3'd6, 16'h4040); @(negedge clk); check("R9 W1C clears irq", irq, 0);
        rd(3'd6, rv); check("R9 event cleared", rv, 16'h4020);
        // R7 overflow
        for (int i = 0; i < DEPTH; i++) wr(3'd0, pw(DEPTH, i));
        rd(3'd3, rv); check("R6 full bit", rv, 16'h0005);
        rd(3'd6, rv); check("R9 not free when full", rv[5], 0);
        wr(3'd0, 16'hFFFF);
        rd(3'd3, rv); check("R7 error set", rv, 16'h000D);
        rd(3'd3, rv); check("R7 error cleared by read", rv, 16'h0005);
        wr(3'd1, 16'h8000);
        recv(DEPTH, 16'hABCD, 16'h1234, 8'h00, 1);
        // R2 R3 R5 sweep over all payload lengths
        for (int n = 0; n < DEPTH; n++) send(n, n);
        // R5 wrap of the block counter
        while (pkts < 256) send(0, pkts);
        check("R5 counter at wrap", pkts, 256);
        pkts = 0;
        send(2, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule